// File: doc/BRIEF.md
# Configurable GPIO Port with Shared Edge Interrupt

This block controls a port of up to eight general-purpose pins through a small register bus. Each pin has its own four-bit configuration register. The bits set the pin's direction, choose its input threshold (TTL or CMOS), enable its interrupt and set the interrupt polarity. One data register holds the output values that pins in output mode drive. A read of the data register returns the synchronised level present on the pins, not the stored value.

Pin levels go through a two-flop synchroniser. The polarity bit is then applied, and each pin is checked for an inactive-to-active edge. All pins share one interrupt request line, which pulses for one cycle when an edge is accepted. After a pulse the line stays disarmed until every enabled pin is back at its inactive level. A pin in output mode is still observed by its own detector, so firmware can raise an interrupt by driving that pin. The narrow variant of the port has four pins. On that variant the unused data bits are reserved.

Top module: `gpio_shared_irq`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0) with its pull-up request asserted (`pin_pullup` = all ones), CMOS threshold is selected (`pin_ttl` = 0), `pin_out` = 0 and `irq` = 0.
- R2: The configuration register of pin i is at bus address i+1. It stores write bits 0 (interrupt enable), 1 (active-low polarity), 2 (TTL threshold) and 3 (output enable). A read returns those four bits with bits 7:4 at zero.
- R3: One cycle after a write, `pin_out` shows the write to address 0. `pin_oe` and `pin_ttl` show configuration bits 3 and 2, and `pin_pullup` is the inverse of `pin_oe`.
- R4: A read of address 0 returns the pin levels after two synchroniser stages, not the last value written.
- R5: With polarity bit 0, a rising edge on an enabled pin produces a one-cycle `irq` pulse. The pulse appears on the third rising clock edge after the pin changes. A falling edge produces no pulse.
- R6: With polarity bit 1, a falling edge on an enabled pin produces the pulse and a rising edge does not.
- R7: A pin whose interrupt enable is 0 never causes an `irq` pulse.
- R8: After a pulse, no further pulse is produced until every enabled pin has returned to its inactive level. Pins that are active but not enabled do not hold the line disarmed.
- R9: A pin in output mode with its interrupt enabled raises `irq` when the data register drives it to its active level.
- R10: When `NPINS` is less than the data width, data bits at and above `NPINS` read as zero and writes to them are ignored. Addresses above `NPINS` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 = data, i+1 = configuration of pin i) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Level sensed at each pad |
| pin_out | output | NPINS | Value driven on pins in output mode |
| pin_oe | output | NPINS | Output enable for each pin |
| pin_pullup | output | NPINS | Pull-up request for each pin (set while the pin is an input) |
| pin_ttl | output | NPINS | Threshold select for each pin (1 = TTL, 0 = CMOS) |
| irq | output | 1 | Shared interrupt request, one-cycle pulse |

## Verification
A register write changes the pad controls on the clock edge that captures it. The bench therefore samples them on the falling edge right after the write. A pin change reaches the data-register readback after two clock edges and reaches `irq` on the third. The R5 check samples `irq` at each of the first four falling edges after the change and expects the pulse only at the third. The other interrupt checks count pulses over a window of at least five cycles, and each new stimulus is applied after that window ends. An output-driven interrupt adds one edge for the data register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int CFG_BITS  = 4;
   localparam int ADDR_DATA = 0;

   // bit 0: interrupt enable, 1: active low, 2: TTL threshold, 3: output enable
   typedef struct packed {
      logic oe;
      logic ttl;
      logic act_low;
      logic int_en;
   } pin_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];

   generate
      if (STAGES == 2) begin : g_chk2
         logic [1:0] warm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          warm <= '0;
            else if (warm != 2'd2) warm <= warm + 2'd1;
         end
         AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd2) |-> (dout == $past(din, 2)));  // R4
      end
   endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [NPINS-1:0]        lvl,
   output logic [DATA_W-1:0]       rdata,
   output logic [NPINS-1:0]        data_q,
   output pin_cfg_t [NPINS-1:0]    cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cfg    <= '0;
      end else if (wr) begin
         if (addr == ADDR_W'(ADDR_DATA)) data_q <= wdata[NPINS-1:0];
         for (int i = 0; i < NPINS; i++) begin
            if (addr == ADDR_W'(i + 1)) cfg[i] <= pin_cfg_t'(wdata[CFG_BITS-1:0]);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_DATA)) rdata[NPINS-1:0] = lvl;
      for (int i = 0; i < NPINS; i++) begin
         if (addr == ADDR_W'(i + 1)) rdata[CFG_BITS-1:0] = cfg[i];
      end
   end

   generate
      if (NPINS < DATA_W) begin : g_reserved
         AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == ADDR_W'(ADDR_DATA)) |-> (rdata[DATA_W-1:NPINS] == '0));  // R10
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_arb.sv
module gpio_irq_arb #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] act_low,
   input  logic [NPINS-1:0] int_en,
   output logic             irq
);

   logic [NPINS-1:0] adj, adj_prev, rise;
   logic             any_active, armed, fire;

   assign adj        = lvl ^ act_low;
   assign rise       = adj & ~adj_prev & int_en;
   assign any_active = |(adj & int_en);
   assign fire       = armed & (|rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_prev <= '0;
         armed    <= 1'b1;
         irq      <= 1'b0;
      end else begin
         adj_prev <= adj;
         irq      <= fire;
         if (fire)             armed <= 1'b0;
         else if (!any_active) armed <= 1'b1;
      end
   end

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);  // R5
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && any_active) |=> !irq);  // R8

endmodule

// File: rtl/gpio_shared_irq.sv
module gpio_shared_irq
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_pullup,
   output logic [NPINS-1:0]  pin_ttl,
   output logic              irq
);

   generate
      if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
         $error("NPINS must lie between 1 and DATA_W");
      end
      if (DATA_W < CFG_BITS) begin : g_bad_width
         $error("DATA_W too narrow for configuration bits");
      end
      if ((1 << ADDR_W) <= NPINS) begin : g_bad_addr
         $error("ADDR_W cannot address every configuration register");
      end
   endgenerate

   logic [NPINS-1:0]     lvl_s;
   pin_cfg_t [NPINS-1:0] cfg;
   logic [NPINS-1:0]     en_v, low_v;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (lvl_s)
   );

   gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .lvl   (lvl_s),
      .rdata (bus_rdata),
      .data_q(pin_out),
      .cfg   (cfg)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_oe[i]     = cfg[i].oe;
      assign pin_pullup[i] = ~cfg[i].oe;
      assign pin_ttl[i]    = cfg[i].ttl;
      assign en_v[i]       = cfg[i].int_en;
      assign low_v[i]      = cfg[i].act_low;

      AST_CFG_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == ADDR_W'(i + 1)) |=>
         (pin_oe[i] == $past(bus_wdata[3]) && pin_ttl[i] == $past(bus_wdata[2])));  // R3
   end

   gpio_irq_arb #(.NPINS(NPINS)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s),
      .act_low(low_v),
      .int_en (en_v),
      .irq    (irq)
   );

   AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ADDR_DATA)) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));  // R3
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|en_v));  // R7

endmodule

// File: tb/sim_gpio_shared_irq.sv
module sim_gpio_shared_irq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       wr0 = 1'b0, wr1 = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata0, rdata1;
   logic [7:0] ext0 = '0;
   logic [3:0] ext1 = '0;
   logic [7:0] pad0, out0, oe0, pu0, ttl0;
   logic [3:0] pad1, out1, oe1, pu1, ttl1;
   logic       irq0, irq1;

   assign pad0 = (oe0 & out0) | (~oe0 & ext0);
   assign pad1 = (oe1 & out1) | (~oe1 & ext1);

   gpio_shared_irq u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata0), .pin_in(pad0), .pin_out(out0), .pin_oe(oe0),
      .pin_pullup(pu0), .pin_ttl(ttl0), .irq(irq0)
   );

   gpio_shared_irq #(.NPINS(4)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata1), .pin_in(pad1), .pin_out(out1), .pin_oe(oe1),
      .pin_pullup(pu1), .pin_ttl(ttl1), .irq(irq1)
   );

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input bit unit, input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr0 = !unit; wr1 = unit;
      @(negedge clk);
      wr0 = 1'b0; wr1 = 1'b0;
   endtask

   task automatic bus_read(input bit unit, input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = unit ? rdata1 : rdata0;
   endtask

   task automatic pulses(input int n, output int cnt);
      cnt = 0;
      repeat (n) begin
         @(negedge clk);
         if (irq0) cnt++;
      end
   endtask

   task automatic set_ext(input logic [7:0] v);
      @(negedge clk);
      ext0 = v;
   endtask

   initial begin
      logic [7:0] rd;
      int         cnt;
      logic [7:0] seen;
      logic [7:0] pat [4];
      pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h5A; pat[3] = 8'h0F;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pin_oe", oe0, 8'h00);
      check("R1 pin_pullup", pu0, 8'hFF);
      check("R1 pin_ttl", ttl0, 8'h00);
      check("R1 pin_out", out0, 8'h00);
      check("R1 irq", irq0, 1'b0);
      bus_read(0, 4'd0, rd);
      check("R1 data read", rd, 8'h00);

      // R2 configuration sweep, all pins, all 16 values, junk in upper bits
      for (int p = 0; p < 8; p++) begin
         for (int v = 0; v < 16; v++) begin
            bus_write(0, 4'(p + 1), {4'(v ^ p), 4'(v)});
            bus_read(0, 4'(p + 1), rd);
            check("R2 cfg readback", rd, 8'(v));
         end
         bus_write(0, 4'(p + 1), 8'h00);
      end

      // R3 pad controls: even pins output + TTL
      for (int p = 0; p < 8; p++) bus_write(0, 4'(p + 1), (p % 2 == 0) ? 8'h0C : 8'h00);
      bus_write(0, 4'd0, 8'hC3);
      check("R3 pin_out", out0, 8'hC3);
      check("R3 pin_oe", oe0, 8'h55);
      check("R3 pin_pullup", pu0, 8'hAA);
      check("R3 pin_ttl", ttl0, 8'h55);

      // R4 live pin readback for several external patterns
      for (int k = 0; k < 4; k++) begin
         set_ext(pat[k]);
         repeat (3) @(negedge clk);
         bus_read(0, 4'd0, rd);
         check("R4 data read is pin level", rd, (8'h55 & 8'hC3) | (8'hAA & pat[k]));
      end
      for (int p = 0; p < 8; p++) bus_write(0, 4'(p + 1), 8'h00);
      bus_write(0, 4'd0, 8'h00);
      set_ext(8'h00);
      pulses(6, cnt);

      // R5 rising edge timing on pin 2
      bus_write(0, 4'd3, 8'h01);
      pulses(4, cnt);
      @(negedge clk);
      ext0[2] = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         seen[k-1] = irq0;
      end
      check("R5 pulse on third edge only", seen[3:0], 4'b0100);
      set_ext(8'h00);
      pulses(6, cnt);
      check("R5 falling edge silent", cnt, 0);
      set_ext(8'h04);
      pulses(6, cnt);
      check("R5 second rising edge", cnt, 1);
      bus_write(0, 4'd3, 8'h00);
      set_ext(8'h00);
      pulses(6, cnt);

      // R6 active-low on pin 5
      set_ext(8'h20);
      pulses(5, cnt);
      bus_write(0, 4'd6, 8'h03);
      pulses(6, cnt);
      check("R6 no pulse at enable while inactive", cnt, 0);
      set_ext(8'h00);
      pulses(6, cnt);
      check("R6 falling edge fires", cnt, 1);
      set_ext(8'h20);
      pulses(6, cnt);
      check("R6 rising edge silent", cnt, 0);
      bus_write(0, 4'd6, 8'h00);
      set_ext(8'h00);
      pulses(6, cnt);

      // R7 disabled pins never interrupt
      set_ext(8'hFF);
      pulses(6, cnt);
      set_ext(8'h00);
      pulses(6, cnt);
      set_ext(8'hFF);
      pulses(6, cnt);
      check("R7 disabled pins silent", cnt, 0);
      set_ext(8'h00);
      pulses(6, cnt);

      // R8 shared re-arm on pins 0 and 1
      bus_write(0, 4'd1, 8'h01);
      bus_write(0, 4'd2, 8'h01);
      pulses(4, cnt);
      set_ext(8'h01);
      pulses(6, cnt);
      check("R8 first source fires", cnt, 1);
      set_ext(8'h03);
      pulses(6, cnt);
      check("R8 second source held off", cnt, 0);
      set_ext(8'h02);
      pulses(6, cnt);
      set_ext(8'h03);
      pulses(6, cnt);
      check("R8 still held off while pin1 active", cnt, 0);
      set_ext(8'h00);
      pulses(6, cnt);
      set_ext(8'h02);
      pulses(6, cnt);
      check("R8 re-armed after all inactive", cnt, 1);
      set_ext(8'h00);
      pulses(6, cnt);
      set_ext(8'h80);
      pulses(6, cnt);
      set_ext(8'h81);
      pulses(6, cnt);
      check("R8 disabled active pin does not block", cnt, 1);
      bus_write(0, 4'd1, 8'h00);
      bus_write(0, 4'd2, 8'h00);
      set_ext(8'h00);
      pulses(6, cnt);

      // R9 output-driven interrupt on pin 4
      bus_write(0, 4'd5, 8'h09);
      pulses(5, cnt);
      check("R9 no pulse before drive", cnt, 0);
      bus_write(0, 4'd0, 8'h10);
      pulses(6, cnt);
      check("R9 output drive fires", cnt, 1);
      bus_write(0, 4'd0, 8'h00);
      bus_write(0, 4'd5, 8'h00);
      pulses(6, cnt);

      // R10 narrow variant
      bus_write(1, 4'd0, 8'hFF);
      check("R10 narrow pin_out", out1, 4'hF);
      @(negedge clk);
      ext1 = 4'hA;
      repeat (3) @(negedge clk);
      bus_read(1, 4'd0, rd);
      check("R10 reserved bits read zero", rd, 8'h0A);
      bus_write(1, 4'd5, 8'hFF);
      bus_read(1, 4'd5, rd);
      check("R10 unmapped address reads zero", rd, 8'h00);
      bus_read(0, 4'd9, rd);
      check("R10 unmapped address wide reads zero", rd, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule